// File: doc/BRIEF.md
# Inter-Thread Register Synchronizer

This block is a small register file placed between a producing task and a consuming task that run in separate hardware thread contexts. Each register carries a presence bit. The bit records whether the producer has delivered the value for the current task. At task start, an externally supplied communicate mask marks which registers carry values between the tasks. The presence bit of every marked register is emptied.

The consumer raises a read request with a register index. The block answers in the same cycle with either valid plus data, or stall. If the consumer arrives first on an empty marked register, it stalls. It is released in the very cycle the producer writes that register, and the written value is passed straight through to the read port. If the producer arrives first, it writes and moves on. A later read finds the register full and completes without stalling. Registers outside the mask behave as plain storage and never stall.

Top module: `xfer_reg_sync`

## Requirements
- R1: After reset the communicate mask and all presence bits are zero, so a read of any index gives rd_valid=1 and rd_stall=0.
- R2: A cycle with task_start=1 loads comm_mask, where bit i set means register i is communicated. In the following cycles, every register whose mask bit was set reads as empty until it is written again.
- R3: A read of a communicated, empty register, with no write to the same index in that cycle, gives rd_stall=1 and rd_valid=0.
- R4: When wr_en=1 and wr_idx equals rd_idx during a read, rd_valid=1 and rd_data equals wr_data in that same cycle, for any register.
- R5: A write sets the register's presence bit. A later read of that index returns the written data with rd_valid=1 and no stall.
- R6: A read does not empty a register, so repeated reads of a full register keep returning valid data.
- R7: A read of a register not set in the loaded mask never stalls and returns its stored contents.
- R8: A write to a different index does not release a stalled read.
- R9: A write in the same cycle as task_start belongs to the new task. The written register is full afterwards, even if its mask bit is set.
- R10: With rd_req=0, both rd_valid and rd_stall are 0.
- R11: A read in the task_start cycle sees the mask and presence state from before the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| task_start | input | 1 | Begin a new task; load mask, empty masked registers |
| comm_mask | input | NREG (32) | Communicated-register mask, sampled on task_start |
| wr_en | input | 1 | Producer write strobe |
| wr_idx | input | IW (5) | Producer register index |
| wr_data | input | W (32) | Producer write value |
| rd_req | input | 1 | Consumer read request |
| rd_idx | input | IW (5) | Consumer register index |
| rd_valid | output | 1 | Read completes this cycle |
| rd_stall | output | 1 | Read must wait; value not yet produced |
| rd_data | output | W (32) | Read value, forwarded when written this cycle |

## Verification
The read port is tried against both arrival orders on the same masked register. Consumer-first must stall until the producer's write and then see the forwarded word in that cycle. Producer-first must read without stalling one or more cycles later. Writes to neighbouring indices during a stall show that only a matching index releases the consumer. Reads of unmasked, never-written indices show that they are not gated by presence. Task starts are placed on cycles that also carry a read or a write, and masks include indices 0 and 31, to separate pre-start state from post-start state and the write-over-clear priority.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  localparam int unsigned XRS_NREG_DEF  = 32;
  localparam int unsigned XRS_WIDTH_DEF = 32;
endpackage

// File: rtl/xrs_store.sv
module xrs_store #(
  parameter int unsigned NREG = 32,
  parameter int unsigned W    = 32,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  // single write port, asynchronous read: maps onto distributed RAM
  logic [W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/xrs_presence.sv
module xrs_presence #(
  parameter int unsigned NREG = 32,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NREG-1:0] mask_in,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [IW-1:0]   ridx,
  output logic            r_full,
  output logic            r_comm
);
  logic [NREG-1:0] full_q;
  logic [NREG-1:0] comm_q;

  always_ff @(posedge clk) begin
    if (rst)        comm_q <= '0;
    else if (start) comm_q <= mask_in;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                           full_q[i] <= 1'b0;
      else if (we && widx == IW'(i))     full_q[i] <= 1'b1;  // write wins over clear
      else if (start && mask_in[i])      full_q[i] <= 1'b0;
    end
  end

  assign r_full = full_q[ridx];
  assign r_comm = comm_q[ridx];
endmodule

// File: rtl/xrs_resolve.sv
module xrs_resolve #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 5
) (
  input  logic          req,
  input  logic [IW-1:0] ridx,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  stored,
  input  logic          full,
  input  logic          comm,
  output logic          valid,
  output logic          stall,
  output logic [W-1:0]  data
);
  logic hit;
  logic ready;

  always_comb begin
    hit   = we && (widx == ridx);
    ready = !comm || full || hit;
    valid = req && ready;
    stall = req && !ready;
    data  = hit ? wdata : stored;
  end
endmodule

// File: rtl/xfer_reg_sync.sv
module xfer_reg_sync #(
  parameter int unsigned NREG = xrs_pkg::XRS_NREG_DEF,
  parameter int unsigned W    = xrs_pkg::XRS_WIDTH_DEF,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            task_start,
  input  logic [NREG-1:0] comm_mask,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [W-1:0]    wr_data,
  input  logic            rd_req,
  input  logic [IW-1:0]   rd_idx,
  output logic            rd_valid,
  output logic            rd_stall,
  output logic [W-1:0]    rd_data
);
  logic [W-1:0] stored;
  logic         is_full;
  logic         is_comm;

  xrs_store #(.NREG(NREG), .W(W)) u_store (
    .clk(clk), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
    .ridx(rd_idx), .rdata(stored)
  );

  xrs_presence #(.NREG(NREG)) u_pres (
    .clk(clk), .rst(rst), .start(task_start), .mask_in(comm_mask),
    .we(wr_en), .widx(wr_idx), .ridx(rd_idx),
    .r_full(is_full), .r_comm(is_comm)
  );

  xrs_resolve #(.W(W), .IW(IW)) u_res (
    .req(rd_req), .ridx(rd_idx), .we(wr_en), .widx(wr_idx), .wdata(wr_data),
    .stored(stored), .full(is_full), .comm(is_comm),
    .valid(rd_valid), .stall(rd_stall), .data(rd_data)
  );
endmodule

// File: rtl/xfer_reg_sync_chk.sv
module xfer_reg_sync_chk #(
  parameter int unsigned NREG = 32,
  parameter int unsigned W    = 32,
  localparam int unsigned IW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst,
  input logic            task_start,
  input logic [NREG-1:0] comm_mask,
  input logic            wr_en,
  input logic [IW-1:0]   wr_idx,
  input logic [W-1:0]    wr_data,
  input logic            rd_req,
  input logic [IW-1:0]   rd_idx,
  input logic            rd_valid,
  input logic            rd_stall,
  input logic [W-1:0]    rd_data
);
  logic            st_q, wr_q, wrote_q;
  logic [IW-1:0]   widx_q;
  logic [W-1:0]    wdat_q;
  logic [NREG-1:0] msk_q, shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= 1'b0; wr_q <= 1'b0; wrote_q <= 1'b0;
      widx_q <= '0; wdat_q <= '0; msk_q <= '0; shadow <= '0;
    end else begin
      st_q <= task_start; wr_q <= wr_en; wrote_q <= wr_en;
      widx_q <= wr_idx; wdat_q <= wr_data; msk_q <= comm_mask;
      if (task_start) shadow <= comm_mask;
    end
  end

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_req |-> (!rd_valid && !rd_stall));

  p_valid_or_stall_r3: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_valid != rd_stall));

  p_forward_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && wr_en && wr_idx == rd_idx) |-> (rd_valid && rd_data == wr_data));

  p_hold_after_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wrote_q && rd_req && rd_idx == widx_q && !(wr_en && wr_idx == rd_idx))
      |-> (rd_valid && rd_data == wdat_q));

  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q && msk_q[rd_idx] && rd_req && !(wr_q && widx_q == rd_idx)
      && !(wr_en && wr_idx == rd_idx)) |-> rd_stall);

  p_unmasked_go_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !shadow[rd_idx]) |-> rd_valid);
endmodule

bind xfer_reg_sync xfer_reg_sync_chk #(.NREG(NREG), .W(W)) u_chk (
  .clk(clk), .rst(rst), .task_start(task_start), .comm_mask(comm_mask),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_req(rd_req), .rd_idx(rd_idx),
  .rd_valid(rd_valid), .rd_stall(rd_stall), .rd_data(rd_data)
);

// File: tb/xfer_reg_sync_tb_top.sv
module xfer_reg_sync_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        task_start;
  logic [31:0] comm_mask;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic        rd_req;
  logic [4:0]  rd_idx;
  logic        rd_valid, rd_stall;
  logic [31:0] rd_data;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  xfer_reg_sync dut_i (
    .clk(clk), .rst(rst), .task_start(task_start), .comm_mask(comm_mask),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_req(rd_req), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_stall(rd_stall), .rd_data(rd_data)
  );

  typedef struct packed {
    logic        st;  logic [31:0] msk;
    logic        we;  logic [4:0]  wi;  logic [31:0] wd;
    logic        rq;  logic [4:0]  ri;
    logic        ev;  logic        cd;  logic [31:0] ed;
    logic [7:0]  rq_tag;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h0000_00F0, 1'b0, 5'd0,  32'h0,         1'b0, 5'd0,  1'b0, 1'b0, 32'h0,         8'd10}, // R10 start
    '{1'b0, 32'h0,         1'b0, 5'd0,  32'h0,         1'b1, 5'd4,  1'b0, 1'b0, 32'h0,         8'd3},  // R3 consumer first
    '{1'b0, 32'h0,         1'b1, 5'd4,  32'hA5A5_0004, 1'b1, 5'd4,  1'b1, 1'b1, 32'hA5A5_0004, 8'd4},  // R4 forward
    '{1'b0, 32'h0,         1'b0, 5'd0,  32'h0,         1'b1, 5'd4,  1'b1, 1'b1, 32'hA5A5_0004, 8'd6},  // R6 re-read
    '{1'b0, 32'h0,         1'b1, 5'd5,  32'h1234_5678, 1'b0, 5'd0,  1'b0, 1'b0, 32'h0,         8'd10}, // producer first
    '{1'b0, 32'h0,         1'b0, 5'd0,  32'h0,         1'b1, 5'd5,  1'b1, 1'b1, 32'h1234_5678, 8'd5},  // R5
    '{1'b0, 32'h0,         1'b1, 5'd1,  32'hDEAD_0001, 1'b0, 5'd0,  1'b0, 1'b0, 32'h0,         8'd10},
    '{1'b0, 32'h0,         1'b0, 5'd0,  32'h0,         1'b1, 5'd1,  1'b1, 1'b1, 32'hDEAD_0001, 8'd7},  // R7
    '{1'b0, 32'h0,         1'b0, 5'd0,  32'h0,         1'b1, 5'd2,  1'b1, 1'b0, 32'h0,         8'd7},  // R7 never written
    '{1'b0, 32'h0,         1'b1, 5'd6,  32'h0000_0066, 1'b1, 5'd7,  1'b0, 1'b0, 32'h0,         8'd8},  // R8
    '{1'b1, 32'h0000_0020, 1'b0, 5'd0,  32'h0,         1'b1, 5'd4,  1'b1, 1'b1, 32'hA5A5_0004, 8'd11}, // R11
    '{1'b0, 32'h0,         1'b0, 5'd0,  32'h0,         1'b1, 5'd4,  1'b1, 1'b1, 32'hA5A5_0004, 8'd7},
    '{1'b0, 32'h0,         1'b0, 5'd0,  32'h0,         1'b1, 5'd5,  1'b0, 1'b0, 32'h0,         8'd2},  // R2 cleared
    '{1'b1, 32'h0000_0040, 1'b1, 5'd6,  32'h0000_0077, 1'b0, 5'd0,  1'b0, 1'b0, 32'h0,         8'd10},
    '{1'b0, 32'h0,         1'b0, 5'd0,  32'h0,         1'b1, 5'd6,  1'b1, 1'b1, 32'h0000_0077, 8'd9},  // R9
    '{1'b1, 32'h8000_0001, 1'b0, 5'd0,  32'h0,         1'b0, 5'd0,  1'b0, 1'b0, 32'h0,         8'd10},
    '{1'b0, 32'h0,         1'b0, 5'd0,  32'h0,         1'b1, 5'd31, 1'b0, 1'b0, 32'h0,         8'd2},  // R2 top index
    '{1'b0, 32'h0,         1'b1, 5'd31, 32'hF000_001F, 1'b1, 5'd0,  1'b0, 1'b0, 32'h0,         8'd8},
    '{1'b0, 32'h0,         1'b0, 5'd0,  32'h0,         1'b1, 5'd31, 1'b1, 1'b1, 32'hF000_001F, 8'd5},
    '{1'b0, 32'h0,         1'b1, 5'd0,  32'h0,         1'b1, 5'd0,  1'b1, 1'b1, 32'h0,         8'd4}   // R4 index 0
  };

  task automatic drive(input logic st, input logic [31:0] msk, input logic we,
                       input logic [4:0] wi, input logic [31:0] wd,
                       input logic rq, input logic [4:0] ri);
    @(negedge clk);
    task_start = st; comm_mask = msk; wr_en = we; wr_idx = wi; wr_data = wd;
    rd_req = rq; rd_idx = ri;
    #1;
  endtask

  task automatic check(input int tag, input logic ev, input logic cd, input logic [31:0] ed);
    logic es;
    es = rd_req && !ev;
    n_run++;
    if (rd_valid !== ev || rd_stall !== es || (cd && rd_data !== ed)) begin
      n_fail++;
      $display("FAIL R%0d: valid=%b stall=%b data=%h, expected valid=%b stall=%b data=%h",
               tag, rd_valid, rd_stall, rd_data, ev, es, ed);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: expired, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; task_start = 0; comm_mask = '0; wr_en = 0; wr_idx = '0; wr_data = '0;
    rd_req = 0; rd_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state, both ends of the index range
    drive(0, 0, 0, 0, 0, 1, 5'd0);  check(1, 1'b1, 1'b0, 32'h0);
    drive(0, 0, 0, 0, 0, 1, 5'd31); check(1, 1'b1, 1'b0, 32'h0);
    // R10: idle port
    drive(0, 0, 0, 0, 0, 0, 5'd3);  check(10, 1'b0, 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].st, VEC[i].msk, VEC[i].we, VEC[i].wi, VEC[i].wd, VEC[i].rq, VEC[i].ri);
      check(int'(VEC[i].rq_tag), VEC[i].ev, VEC[i].cd, VEC[i].ed);
    end

    // R3 held stall across several cycles, then R4 release
    drive(1, 32'h0000_0100, 0, 0, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      drive(0, 0, 0, 0, 0, 1, 5'd8); check(3, 1'b0, 1'b0, 32'h0);
    end
    drive(0, 0, 1, 5'd8, 32'hCAFE_0008, 1, 5'd8); check(4, 1'b1, 1'b1, 32'hCAFE_0008);

    // R1: reset mid-run empties the mask again
    drive(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
    @(negedge clk) rst = 1'b1; task_start = 0;
    @(negedge clk) rst = 1'b0;
    drive(0, 0, 0, 0, 0, 1, 5'd12); check(1, 1'b1, 1'b0, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule